// File: doc/BRIEF.md
# Telephony Serial Frame Port

This block is a synchronous serial port for a telephony codec. One serial link carries audio samples and control-register traffic. The port runs as the link master. It divides its master clock down to a bit clock, emits the frame sync and exchanges one 16-bit sample word in each direction at the start of every 256-bit frame. The outgoing sample comes in parallel on `rxWord`, and the incoming sample is handed out on `txWord` with a one-cycle strobe.

Control traffic uses an optional second word, which begins 128 bit clocks after the frame starts. The host asks for it in one of two ways. In the default mode it sets the low bit of its sample word; in full-width mode it raises the `fcReq` input instead. Each secondary word reads or writes one 8-bit register in a small internal register file. That file also holds the mode bit and the bit-clock divider.

Top module: `tel_frame_port`

## Requirements
- R1: Out of reset, `sclkOut`, `fsyncOut`, `sdo` and `txValid` are low. Each frame lasts exactly 256 bit-clock periods.
- R2: `fsyncOut` is high for exactly one bit period, in the bit just before the MSB of each word. A sync precedes the primary word in every frame, and no other sync appears.
- R3: Data moves MSB first. It is driven on the rising edge of `sclkOut` and sampled on the falling edge. The primary word on `sdo` is the value of `rxWord` taken at the frame start.
- R4: While register 1 bit 0 is 0 (the reset state), `txWord` carries incoming bits 15..1 with bit 0 forced to 0. Incoming bit 0 set to 1 requests a secondary word, and `fcReq` has no effect.
- R5: While register 1 bit 0 is 1, `txWord` is the full 16-bit incoming word. A secondary word is requested only by `fcReq` being high at the last primary bit, and incoming bit 0 has no effect.
- R6: A secondary word, with its own sync, starts 128 bit clocks after the primary MSB, and only in a frame whose primary word made a request. Otherwise `sdo` stays 0 over that slot.
- R7: In a secondary command, bit 15 = 1 selects a read and bits 12..8 give the address. The addressed 8-bit register then appears on `sdo` in bits 7..0 of that word, and bits 15..8 are 0.
- R8: With bit 15 = 0, the command writes bits 7..0 into the register at bits 12..8. Bits 14..13 are ignored, and only one register is accessed per secondary word.
- R9: Registers exist only at addresses 0..3. Writes to other addresses are discarded, and reads from them return 0.
- R10: Register 2 (reset 2) sets the `sclkOut` period in master clocks. A written value is rounded down to even, and values below 2 become 2. A new value applies from the next frame start.
- R11: A change of register 1 bit 0 applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial data from the host (sample and commands) |
| fcReq | input | 1 | Hardware request for a secondary word |
| rxWord | input | 16 | Sample to send in the next primary word |
| sclkOut | output | 1 | Bit clock |
| fsyncOut | output | 1 | Frame/word sync pulse |
| sdo | output | 1 | Serial data to the host |
| txWord | output | 16 | Last sample received from the host |
| txValid | output | 1 | One-cycle strobe when `txWord` updates |

## Verification
The assertions check the following on every cycle: the sync pulse lasts one bit, the divider counter stays below an even divider of at least 2, the mode bit changes only at a frame start, and in default mode the received sample always has a cleared low bit. The bench scenarios are needed for the rest: the frame length, the presence of a secondary word depending on which request method is active, read-after-write through the serial link, discarded writes to unmapped addresses, and the bit period after divider writes with odd and too-small values.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  localparam int WORD_W     = 16;
  localparam int FRAME_BITS = 256;
  localparam int SEC_START  = 128;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int IDX_W      = $clog2(WORD_W);
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  // command layout: [15] read flag, [12:8] address, [7:0] data
  localparam int CMD_RW     = 15;
  localparam int ADDR_LSB   = 8;

  typedef struct packed {
    logic             rise;      // bit clock goes high at this edge
    logic             fall;      // bit clock goes low at this edge
    logic             primNow;   // current bit in primary slot
    logic             secNow;    // current bit in active secondary slot
    logic [IDX_W-1:0] idxNow;
    logic             primNext;  // bit entered at a rise is primary
    logic             secNext;
    logic [IDX_W-1:0] idxNext;
    logic             fullWidth; // mode latched for this frame
  } strobe_t;
endpackage

// File: rtl/tfp_regs.sv
module tfp_regs
  import tfp_pkg::*;
#(
  parameter int                NUM_REGS  = 4,
  parameter int                CTRL_ADDR = 1,
  parameter int                DIV_ADDR  = 2,
  parameter logic [DATA_W-1:0] DIV_RESET = 8'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              fullWidthReg,
  output logic [DATA_W-1:0] divReg
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regFile [NUM_REGS];

  function automatic logic [DATA_W-1:0] evenClamp(input logic [DATA_W-1:0] d);
    return (d < DATA_W'(2)) ? DATA_W'(2) : {d[DATA_W-1:1], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN)
        regFile[i] <= (i == DIV_ADDR) ? DIV_RESET : '0;
      else if (wrEn && wrAddr == ADDR_W'(i))
        regFile[i] <= (i == DIV_ADDR) ? evenClamp(wrData) : wrData;
    end
  end

  assign rdData       = (rdAddr < ADDR_W'(NUM_REGS)) ? regFile[rdAddr[SEL_W-1:0]] : '0;
  assign fullWidthReg = regFile[CTRL_ADDR][0];
  assign divReg       = regFile[DIV_ADDR];
endmodule

// File: rtl/tfp_ctrl.sv
module tfp_ctrl
  import tfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fcReq,
  input  logic              txBit0,
  input  logic              fullWidthReg,
  input  logic [DATA_W-1:0] divReg,
  output logic              sclkOut,
  output logic              fsyncOut,
  output strobe_t           strb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] SEC_PRE  = CNT_W'(SEC_START - 1);
  localparam logic [CNT_W-1:0] SEC_BEG  = CNT_W'(SEC_START);
  localparam logic [CNT_W-1:0] SEC_END  = CNT_W'(SEC_START + WORD_W);
  localparam logic [CNT_W-1:0] PRIM_END = CNT_W'(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic [DATA_W-1:0] divCnt, divActive;
  logic [CNT_W-1:0]  bitCnt, nextBit;
  logic              sbActive, secPending, rise, fall;

  assign rise    = (divCnt == divActive - 1'b1);
  assign fall    = (divCnt == (divActive >> 1) - 1'b1);
  assign nextBit = bitCnt + 1'b1;

  always_comb begin
    strb           = '0;
    strb.rise      = rise;
    strb.fall      = fall;
    strb.primNow   = bitCnt < PRIM_END;
    strb.secNow    = secPending && bitCnt >= SEC_BEG && bitCnt < SEC_END;
    strb.idxNow    = strb.primNow ? bitCnt[IDX_W-1:0] : IDX_W'(bitCnt - SEC_BEG);
    strb.primNext  = nextBit < PRIM_END;
    strb.secNext   = secPending && nextBit >= SEC_BEG && nextBit < SEC_END;
    strb.idxNext   = strb.primNext ? nextBit[IDX_W-1:0] : IDX_W'(nextBit - SEC_BEG);
    strb.fullWidth = sbActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt     <= '0;
      divActive  <= DATA_W'(2);
      bitCnt     <= LAST_BIT - 1'b1;  // first rise enters the sync bit
      sclkOut    <= 1'b0;
      fsyncOut   <= 1'b0;
      sbActive   <= 1'b0;
      secPending <= 1'b0;
    end else begin
      divCnt <= rise ? '0 : divCnt + 1'b1;
      if (rise)      sclkOut <= 1'b1;
      else if (fall) sclkOut <= 1'b0;
      if (rise) begin
        bitCnt   <= nextBit;
        fsyncOut <= (nextBit == LAST_BIT) || (nextBit == SEC_PRE && secPending);
        if (nextBit == '0) begin
          sbActive   <= fullWidthReg;
          divActive  <= divReg;
          secPending <= 1'b0;
        end
      end
      if (fall && strb.primNow && strb.idxNow == IDX_LAST)
        secPending <= sbActive ? fcReq : txBit0;
    end
  end

  AST_FSYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (fsyncOut && rise) |=> !fsyncOut);  // R2
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < divActive);  // R10
  AST_DIV_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    !divActive[0] && divActive >= DATA_W'(2));  // R10
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sbActive) |-> bitCnt == '0);  // R11
endmodule

// File: rtl/tfp_dpath.sv
module tfp_dpath
  import tfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  logic [WORD_W-1:0] rxWord,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] rdData,
  output logic              sdo,
  output logic [WORD_W-1:0] txWord,
  output logic              txValid,
  output logic              txBit0,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(WORD_W - DATA_W);
  localparam int               RW_POS   = CMD_RW - ADDR_LSB;  // in upper byte

  logic [WORD_W-2:0] inShift, outShift;
  logic [WORD_W-1:0] wordIn;
  logic              lastPrim, lastSec, isRead;

  assign wordIn   = {inShift, sdi};
  assign lastPrim = strb.fall && strb.primNow && strb.idxNow == IDX_LAST;
  assign lastSec  = strb.fall && strb.secNow  && strb.idxNow == IDX_LAST;
  assign txBit0   = sdi;
  // after the upper byte has arrived, inShift[7:0] holds command bits 15..8
  assign rdAddr   = inShift[ADDR_W-1:0];
  assign isRead   = inShift[RW_POS];
  assign wrEn     = lastSec && !wordIn[CMD_RW];
  assign wrAddr   = wordIn[ADDR_LSB +: ADDR_W];
  assign wrData   = wordIn[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      sdo      <= 1'b0;
      txWord   <= '0;
      txValid  <= 1'b0;
    end else begin
      txValid <= lastPrim;
      if (strb.fall && (strb.primNow || strb.secNow))
        inShift <= wordIn[WORD_W-2:0];
      if (lastPrim)
        txWord <= strb.fullWidth ? wordIn : {wordIn[WORD_W-1:1], 1'b0};
      if (strb.rise) begin
        if (strb.primNext && strb.idxNext == '0)
          {sdo, outShift} <= rxWord;
        else if (strb.secNext && strb.idxNext == IDX_DATA && isRead)
          {sdo, outShift} <= {rdData, (WORD_W-DATA_W)'(0)};
        else
          {sdo, outShift} <= {outShift, 1'b0};
      end
    end
  end

  AST_TX_LSB_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !strb.fullWidth) |-> !txWord[0]);  // R4
  AST_TXVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid);  // R4
endmodule

// File: rtl/tel_frame_port.sv
module tel_frame_port
  import tfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  logic              fcReq,
  input  logic [WORD_W-1:0] rxWord,
  output logic              sclkOut,
  output logic              fsyncOut,
  output logic              sdo,
  output logic [WORD_W-1:0] txWord,
  output logic              txValid
);
  strobe_t           strb;
  logic              txBit0, wrEn, fullWidthReg;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] rdData, wrData, divReg;

  tfp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .fcReq(fcReq), .txBit0(txBit0),
    .fullWidthReg(fullWidthReg), .divReg(divReg),
    .sclkOut(sclkOut), .fsyncOut(fsyncOut), .strb(strb)
  );

  tfp_dpath i_dpath (
    .clk(clk), .rstN(rstN), .sdi(sdi), .rxWord(rxWord), .strb(strb),
    .rdData(rdData), .sdo(sdo), .txWord(txWord), .txValid(txValid),
    .txBit0(txBit0), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData)
  );

  tfp_regs i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .fullWidthReg(fullWidthReg),
    .divReg(divReg)
  );
endmodule

// File: tb/test_tel_frame_port.sv
`timescale 1ns/1ps
module test_tel_frame_port;
  logic        clk = 1'b0, rstN = 1'b0, sdi = 1'b0, fcReq = 1'b0;
  logic [15:0] rxWord = '0;
  logic        sclkOut, fsyncOut, sdo, txValid;
  logic [15:0] txWord;

  int          nChecks = 0, nFails = 0;
  logic [15:0] expTxQ [$];
  bit          firstFrame = 1'b1, done = 1'b0;

  always #5 clk = ~clk;

  tel_frame_port i_tel_frame_port (
    .clk(clk), .rstN(rstN), .sdi(sdi), .fcReq(fcReq), .rxWord(rxWord),
    .sclkOut(sclkOut), .fsyncOut(fsyncOut), .sdo(sdo), .txWord(txWord),
    .txValid(txValid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each received sample with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && txValid) begin
      if (expTxQ.size() == 0) check("R4 R5 unexpected tx strobe", 16'd1, 16'd0);
      else check("R4 R5 tx word", txWord, expTxQ.pop_front());
    end
  end

  task automatic shiftWord(input logic [15:0] outW, output logic [15:0] got);
    for (int i = 15; i >= 0; i--) begin
      @(posedge sclkOut); #1 sdi = outW[i];
      @(negedge sclkOut); #1 got[i] = sdo;
    end
  endtask

  // driver: one full frame as the host sees it
  task automatic runFrame(input string secTag, input logic [15:0] tx, input logic [15:0] rxv,
                          input logic fc, input logic expSec, input logic [15:0] cmd,
                          input logic [15:0] expSecOut, input logic [15:0] expTx,
                          input int expDiv);
    int cnt = 0, extra = 0;
    longint t0 = 0, t1 = 0;
    logic [15:0] got;
    rxWord = rxv;
    fcReq  = fc;
    expTxQ.push_back(expTx);
    do begin @(negedge sclkOut); #1 cnt++; end while (fsyncOut !== 1'b1);
    if (!firstFrame) check("R1 bits from secondary end to next sync", 16'(cnt), 16'd112);
    firstFrame = 1'b0;
    shiftWord(tx, got);
    check("R3 primary word on sdo", got, rxv);
    for (int i = 0; i < 112; i++) begin
      @(negedge sclkOut); #1;
      t0 = t1; t1 = $time;
      if (i < 111 && fsyncOut) extra++;
    end
    check("R2 stray sync in gap", 16'(extra), 16'd0);
    check("R6 secondary sync presence", {15'd0, fsyncOut}, {15'd0, expSec});
    check("R10 bit clock period", 16'((t1 - t0) / 10), 16'(expDiv));
    shiftWord(expSec ? cmd : 16'h0000, got);
    check(secTag, got, expSecOut);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset sclk",  {15'd0, sclkOut},  16'd0);
    check("R1 reset fsync", {15'd0, fsyncOut}, 16'd0);
    check("R1 reset sdo",   {15'd0, sdo},      16'd0);
    check("R1 reset strobe",{15'd0, txValid},  16'd0);
    rstN = 1'b1;
    // default mode: fc ignored, LSB clear -> no secondary
    runFrame("R6 idle slot zero",   16'h1234, 16'hA5C3, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h1234, 2);
    // LSB request, write reg3 with bits 14..13 set
    runFrame("R8 write slot out",   16'h8765, 16'h0F0F, 1'b0, 1'b1, 16'h6355, 16'h0000, 16'h8764, 2);
    runFrame("R7 R8 read back",     16'h0001, 16'hFFFF, 1'b0, 1'b1, 16'h8300, 16'h0055, 16'h0000, 2);
    runFrame("R9 unmapped write",   16'h1111, 16'h8001, 1'b0, 1'b1, 16'h1F77, 16'h0000, 16'h1110, 2);
    runFrame("R9 unmapped read",    16'h0003, 16'h7FFE, 1'b0, 1'b1, 16'h9F00, 16'h0000, 16'h0002, 2);
    runFrame("R11 mode write",      16'h0005, 16'h1357, 1'b0, 1'b1, 16'h0105, 16'h0000, 16'h0004, 2);
    // full-width mode: LSB ignored, fc low -> no secondary
    runFrame("R5 R11 no request",   16'h4321, 16'h2468, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h4321, 2);
    runFrame("R5 read mode reg",    16'h0002, 16'hBEEF, 1'b1, 1'b1, 16'h8100, 16'h0005, 16'h0002, 2);
    runFrame("R10 write odd div",   16'h0000, 16'hC0DE, 1'b1, 1'b1, 16'h0205, 16'h0000, 16'h0000, 2);
    runFrame("R10 read div",        16'h8001, 16'h0001, 1'b1, 1'b1, 16'h8200, 16'h0004, 16'h8001, 4);
    runFrame("R10 write small div", 16'h7777, 16'h8000, 1'b1, 1'b1, 16'h0201, 16'h0000, 16'h7777, 4);
    runFrame("R11 mode clear",      16'h00F1, 16'h5A5A, 1'b1, 1'b1, 16'h0100, 16'h0000, 16'h00F1, 2);
    runFrame("R4 R10 clamped div",  16'h00FF, 16'hA5A5, 1'b0, 1'b1, 16'h8200, 16'h0002, 16'h00FE, 2);
    check("R4 R5 all samples seen", 16'(expTxQ.size()), 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule